// File: doc/BRIEF.md
# Time-Shared Programmable-Length FIR Filter

This block is a finite impulse response filter with sixteen multipliers. Each multiplier is reused over one, two, four or eight system clocks for every input sample, so the filter length can be 16, 32, 64 or 128 taps. More taps mean fewer samples per clock. Samples are 16-bit two's complement values that arrive on a strobe. Coefficients are written as 16-bit words through a write port and are kept internally at 12 bits. Products are summed in 32-bit signed accumulators. A 32-bit partial sum from an upstream stage is added to each result at full width, so several blocks can be chained with no loss of precision.

There are two options. The first, split mode, cuts the multiplier bank in half to make two independent filters. Each half-length filter has its own sample input, cascade input and result. The second, decimate-by-two mode, produces one result for every second accepted sample. Because only half of the samples start a computation, samples can arrive twice as often for a given length.

A controller with two states sequences the work. `ST_IDLE` waits for a sample that starts a computation and then moves to `ST_RUN` with phase 0. In `ST_RUN`, each clock handles one group of taps and advances the phase. On the last phase the controller returns to `ST_IDLE`, unless a new starting sample arrives in that same clock. In that case it stays in `ST_RUN` and restarts at phase 0.

Top module: `fir_multicycle`

## Requirements
- R1: While reset is active and right after it, `out_valid` is 0, `res_a` and `res_b` are 0, and `ovf` is 0.
- R2: A coefficient write stores bits [15:4] of `coef_wdata` at `coef_addr`. The value used is the signed 16-bit word shifted right arithmetically by 4, which rounds toward negative infinity (0xFFFF gives -1, 0x000F gives 0, 0x8000 gives -2048).
- R3: With `len_mode`=0, a sample may arrive on every clock. The result is sum over k=0..15 of x[n-k]*c[k]. It is presented with `out_valid` high two clocks after the clock in which the sample strobe was high.
- R4: With `len_mode`=1, 2 or 3, the filter has 32, 64 or 128 taps. Samples are spaced 2, 4 or 8 clocks apart, and a result follows its starting sample by 2^len_mode+1 clocks.
- R5: Accumulation wraps modulo 2^32 with no saturation. `ovf` becomes 1 when any signed addition overflows, and only reset clears it.
- R6: The cascade input of each filter is added to that filter's sum at full 32-bit width. It is sampled in the last compute clock.
- R7: With `split_en`=1, filter A uses `x_a`, `casc_a`, `res_a` and coefficient addresses k=0..8*2^len_mode-1 for tap k. Filter B uses `x_b`, `casc_b`, `res_b` and address 64+k for tap k. With `split_en`=0, `res_b` holds its value.
- R8: With `decim_en`=1, only the 2nd, 4th, 6th and later samples counted since reset start a computation, and each result is the full filter at that sample. Samples may be spaced max(1, 2^(len_mode-1)) clocks apart.
- R9: `out_valid` is high for exactly one clock for each completed computation, and `res_a`/`res_b` hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_mode | input | 2 | Length select: 16 << len_mode taps (halved per filter in split mode) |
| split_en | input | 1 | Two independent half-length filters |
| decim_en | input | 1 | Decimate-by-two |
| smp_valid | input | 1 | Sample strobe for both channels |
| x_a | input | 16 | Sample for filter A (the only filter when not split) |
| x_b | input | 16 | Sample for filter B |
| casc_a | input | 32 | Upstream partial sum for filter A |
| casc_b | input | 32 | Upstream partial sum for filter B |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 7 | Coefficient address |
| coef_wdata | input | 16 | Coefficient word |
| out_valid | output | 1 | Result strobe |
| res_a | output | 32 | Filter A result |
| res_b | output | 32 | Filter B result |
| ovf | output | 1 | Sticky accumulator overflow flag |

## Verification
The assertions rely on several conditions being met at the inputs:
- Mode inputs change only while the controller is idle.
- Coefficient writes happen only while the controller is idle.
- Samples keep the spacing that the selected mode allows.
- In decimate mode, at most one non-starting sample arrives inside a computation.

The bench meets these conditions. It changes modes and coefficients only after an idle gap that is longer than the longest computation. It issues samples with exactly the spacing of each mode. It changes the cascade inputs only between runs.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;
    localparam int SMP_W = 16;
    localparam int CQ_W  = 12;
    localparam int ACC_W = 32;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [CQ_W-1:0]  cq_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;
endpackage

// File: rtl/fir_mc_seq.sv
module fir_mc_seq
    import fir_mc_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int PH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [LEN_W-1:0] len_mode,
    input  logic             decim_en,
    output logic             run,
    output logic             first,
    output logic             last,
    output logic             off,
    output logic [PH_W-1:0]  phase
);
    seq_st_e         st_q, st_d;
    logic [PH_W-1:0] ph_q, ph_d;
    logic [PH_W-1:0] last_ph;
    logic            pair_q;
    logic            off_q;
    logic            start;
    logic            at_end;

    assign last_ph = PH_W'((1 << len_mode) - 1);
    assign start   = smp_valid && (!decim_en || pair_q);
    assign at_end  = (st_q == ST_RUN) && (ph_q == last_ph);

    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d = ST_RUN;
                    ph_d = '0;
                end
            end
            ST_RUN: begin
                if (ph_q == last_ph) begin
                    ph_d = '0;
                    st_d = start ? ST_RUN : ST_IDLE;
                end else begin
                    ph_d = ph_q + 1'b1;
                end
            end
            default: begin
                st_d = ST_IDLE;
                ph_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= '0;
            pair_q <= 1'b0;
            off_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            if (smp_valid && decim_en)
                pair_q <= ~pair_q;
            if (start)
                off_q <= 1'b0;
            else if (st_q == ST_RUN && !at_end && smp_valid)
                off_q <= 1'b1;
        end
    end

    always_comb begin
        run   = (st_q == ST_RUN);
        first = run && (ph_q == '0);
        last  = at_end;
        off   = off_q;
        phase = ph_q;
    end

    // R4: the phase never passes the last group of the selected length
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase <= last_ph));

    // R8: a sample inside a run is legal only as the first of a decimated pair
    assert_mid_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && smp_valid) |-> (decim_en && !off_q && !pair_q));
endmodule

// File: rtl/fir_mc_hist.sv
module fir_mc_hist
    import fir_mc_pkg::*;
#(
    parameter int DEPTH = 129
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  smp_t din,
    output smp_t taps [DEPTH]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else if (smp_valid) begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/fir_mc_coef.sv
module fir_mc_coef
    import fir_mc_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output cq_t           coef [DEPTH]
);
    localparam int DROP = DW - CQ_W;

    logic unused_lsbs;
    assign unused_lsbs = ^wdata[DROP-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) coef[i] <= '0;
        end else if (we) begin
            coef[addr] <= cq_t'(wdata[DW-1 -: CQ_W]);
        end
    end

    // R2: a written word is kept as its upper bits only
    assert_coef_trunc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (coef[$past(addr)] == $past(wdata[DW-1 -: CQ_W])));
endmodule

// File: rtl/fir_mc_macs.sv
module fir_mc_macs
    import fir_mc_pkg::*;
#(
    parameter int NMAC   = 16,
    parameter int HIST_A = 129,
    parameter int HIST_B = 65,
    parameter int NCOEF  = 128,
    parameter int PH_W   = 3
) (
    input  logic            split,
    input  logic            off,
    input  logic [PH_W-1:0] phase,
    input  smp_t            hist_a [HIST_A],
    input  smp_t            hist_b [HIST_B],
    input  cq_t             coef   [NCOEF],
    output acc_t            grp_a,
    output acc_t            grp_b
);
    localparam int HALF = NMAC / 2;
    localparam int HA_W = $clog2(HIST_A);
    localparam int HB_W = $clog2(HIST_B);
    localparam int CA_W = $clog2(NCOEF);

    acc_t prod [NMAC];

    for (genvar m = 0; m < NMAC; m++) begin : g_mac
        localparam int  MH    = m % HALF;
        localparam bit  UPPER = (m >= HALF);
        int             tap;
        int             hidx;
        logic [CA_W-1:0] caddr;
        smp_t           smp;

        always_comb begin
            tap  = split ? (int'(phase) * HALF + MH) : (int'(phase) * NMAC + m);
            hidx = tap + int'(off);
            if (split && UPPER) begin
                caddr = CA_W'(tap + NCOEF / 2);
                smp   = hist_b[HB_W'(hidx)];
            end else begin
                caddr = CA_W'(tap);
                smp   = hist_a[HA_W'(hidx)];
            end
            prod[m] = acc_t'(smp) * acc_t'(coef[caddr]);
        end
    end

    always_comb begin
        grp_a = '0;
        grp_b = '0;
        for (int m = 0; m < NMAC; m++) begin
            if (split && m >= HALF) grp_b = grp_b + prod[m];
            else                    grp_a = grp_a + prod[m];
        end
    end
endmodule

// File: rtl/fir_multicycle.sv
module fir_multicycle
    import fir_mc_pkg::*;
#(
    parameter int NMAC      = 16,
    parameter int MAX_RATIO = 8,
    parameter int LEN_W     = 2,
    parameter int CW        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LEN_W-1:0]     len_mode,
    input  logic                 split_en,
    input  logic                 decim_en,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     x_a,
    input  logic [SMP_W-1:0]     x_b,
    input  logic [ACC_W-1:0]     casc_a,
    input  logic [ACC_W-1:0]     casc_b,
    input  logic                 coef_we,
    input  logic [$clog2(NMAC*MAX_RATIO)-1:0] coef_addr,
    input  logic [CW-1:0]        coef_wdata,
    output logic                 out_valid,
    output logic [ACC_W-1:0]     res_a,
    output logic [ACC_W-1:0]     res_b,
    output logic                 ovf
);
    localparam int MAX_TAPS = NMAC * MAX_RATIO;
    localparam int AW       = $clog2(MAX_TAPS);
    localparam int PH_W     = $clog2(MAX_RATIO);
    localparam int HIST_A   = MAX_TAPS + 1;
    localparam int HIST_B   = MAX_TAPS / 2 + 1;

    logic            run, first, last, off;
    logic [PH_W-1:0] phase;
    smp_t            hist_a [HIST_A];
    smp_t            hist_b [HIST_B];
    cq_t             coef   [MAX_TAPS];
    acc_t            grp_a, grp_b;

    acc_t acc_a_q, acc_b_q, res_a_q, res_b_q;
    logic vld_q, ovf_q;
    acc_t base_a, base_b, sum_a, sum_b, fin_a, fin_b;
    logic ov_now;

    fir_mc_seq #(.LEN_W(LEN_W), .PH_W(PH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .len_mode(len_mode),
        .decim_en(decim_en), .run(run), .first(first), .last(last),
        .off(off), .phase(phase)
    );

    fir_mc_hist #(.DEPTH(HIST_A)) u_hist_a (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .din(smp_t'(x_a)), .taps(hist_a)
    );

    fir_mc_hist #(.DEPTH(HIST_B)) u_hist_b (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .din(smp_t'(x_b)), .taps(hist_b)
    );

    fir_mc_coef #(.DEPTH(MAX_TAPS), .AW(AW), .DW(CW)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
        .wdata(coef_wdata), .coef(coef)
    );

    fir_mc_macs #(.NMAC(NMAC), .HIST_A(HIST_A), .HIST_B(HIST_B),
                  .NCOEF(MAX_TAPS), .PH_W(PH_W)) u_macs (
        .split(split_en), .off(off), .phase(phase), .hist_a(hist_a),
        .hist_b(hist_b), .coef(coef), .grp_a(grp_a), .grp_b(grp_b)
    );

    function automatic logic add_ov(acc_t a, acc_t b, acc_t s);
        return (a[ACC_W-1] == b[ACC_W-1]) && (s[ACC_W-1] != a[ACC_W-1]);
    endfunction

    always_comb begin
        base_a = first ? '0 : acc_a_q;
        base_b = first ? '0 : acc_b_q;
        sum_a  = base_a + grp_a;
        sum_b  = base_b + grp_b;
        fin_a  = sum_a + $signed(casc_a);
        fin_b  = sum_b + $signed(casc_b);
        ov_now = run && (add_ov(base_a, grp_a, sum_a)
                 || (last && add_ov(sum_a, $signed(casc_a), fin_a))
                 || (split_en && add_ov(base_b, grp_b, sum_b))
                 || (split_en && last && add_ov(sum_b, $signed(casc_b), fin_b)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_a_q <= '0;
            acc_b_q <= '0;
            res_a_q <= '0;
            res_b_q <= '0;
            vld_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            vld_q <= last;
            ovf_q <= ovf_q | ov_now;
            if (run) begin
                acc_a_q <= sum_a;
                if (split_en) acc_b_q <= sum_b;
            end
            if (last) begin
                res_a_q <= fin_a;
                if (split_en) res_b_q <= fin_b;
            end
        end
    end

    assign out_valid = vld_q;
    assign res_a     = res_a_q;
    assign res_b     = res_b_q;
    assign ovf       = ovf_q;

    // R9: a result strobe only follows the final compute clock
    assert_valid_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(last));

    // R5: the overflow flag never drops without reset
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R7: the second result is untouched when the bank is joined
    assert_b_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !split_en |=> $stable(res_b));

    // R3: full-rate mode returns a result two clocks after each sample
    assert_rate1_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len_mode == '0 && !decim_en && smp_valid) |=> ##1 out_valid);
endmodule

// File: tb/fir_multicycle_bench.sv
module fir_multicycle_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  len_mode = '0;
    logic        split_en = 1'b0, decim_en = 1'b0, smp_valid = 1'b0;
    logic [15:0] x_a = '0, x_b = '0;
    logic [31:0] casc_a = '0, casc_b = '0;
    logic        coef_we = 1'b0;
    logic [6:0]  coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic        out_valid, ovf;
    logic [31:0] res_a, res_b;

    fir_multicycle u_fir_multicycle (
        .clk(clk), .rst_n(rst_n), .len_mode(len_mode), .split_en(split_en),
        .decim_en(decim_en), .smp_valid(smp_valid), .x_a(x_a), .x_b(x_b),
        .casc_a(casc_a), .casc_b(casc_b), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .out_valid(out_valid), .res_a(res_a),
        .res_b(res_b), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int    mh_a [128];
    int    mh_b [128];
    int    mc   [128];
    bit    pair_m = 0;
    bit    ovf_m = 0;
    int    ecount = 0;
    int    due_q[$];
    int    ea_q[$];
    int    eb_q[$];
    bit    hb_q[$];
    bit    finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin mh_a[i] = 0; mh_b[i] = 0; mc[i] = 0; end
    end

    // behavioural reference, updated at every edge
    always @(posedge clk) begin
        if (rst_n) begin
            bit start;
            ecount++;
            if (coef_we) mc[coef_addr] = int'($signed(coef_wdata[15:4]));
            start = smp_valid && (!decim_en || pair_m);
            if (smp_valid) begin
                for (int k = 127; k > 0; k--) begin mh_a[k] = mh_a[k-1]; mh_b[k] = mh_b[k-1]; end
                mh_a[0] = int'($signed(x_a));
                mh_b[0] = int'($signed(x_b));
                if (decim_en) pair_m = !pair_m;
            end
            if (start) begin
                int     ratio, taps;
                longint sa, sb;
                ratio = 1 << len_mode;
                taps  = split_en ? 8 * ratio : 16 * ratio;
                sa = 0; sb = 0;
                for (int k = 0; k < taps; k++) begin
                    sa += longint'(mh_a[k]) * mc[k];
                    if (split_en) sb += longint'(mh_b[k]) * mc[64 + k];
                end
                sa += longint'($signed(casc_a));
                sb += longint'($signed(casc_b));
                if (sa > 64'sd2147483647 || sa < -64'sd2147483648) ovf_m = 1;
                if (split_en && (sb > 64'sd2147483647 || sb < -64'sd2147483648)) ovf_m = 1;
                due_q.push_back(ecount + ratio);
                ea_q.push_back(int'(sa[31:0]));
                eb_q.push_back(int'(sb[31:0]));
                hb_q.push_back(split_en);
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (due_q.size() > 0 && due_q[0] == ecount) begin
                int ea, eb;
                bit hb;
                void'(due_q.pop_front());
                ea = ea_q.pop_front();
                eb = eb_q.pop_front();
                hb = hb_q.pop_front();
                chk(out_valid == 1'b1, "R9", "out_valid high", out_valid, 1);
                chk(res_a == ea, cur_req, "res_a", $signed(res_a), ea);
                if (hb) chk(res_b == eb, cur_req, "res_b", $signed(res_b), eb);
            end else begin
                chk(out_valid == 1'b0, "R9", "out_valid low", out_valid, 0);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(int xa, int xb, int gap);
        smp_valid = 1'b1;
        x_a = 16'(xa);
        x_b = 16'(xb);
        tick();
        smp_valid = 1'b0;
        repeat (gap - 1) tick();
    endtask

    task automatic wcoef(int addr, logic [15:0] data);
        coef_we = 1'b1;
        coef_addr = 7'(addr);
        coef_wdata = data;
        tick();
        coef_we = 1'b0;
    endtask

    task automatic drain();
        repeat (24) tick();
    endtask

    function automatic int rsmp();
        return int'($urandom_range(8000)) - 4000;
    endfunction

    task automatic stream(int n, int gap);
        for (int i = 0; i < n; i++) send(rsmp(), rsmp(), gap);
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(res_a == 32'd0, "R1", "res_a in reset", res_a, 0);
        chk(res_b == 32'd0, "R1", "res_b in reset", res_b, 0);
        chk(ovf == 1'b0, "R1", "ovf in reset", ovf, 0);
        tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(out_valid == 1'b0 && ovf == 1'b0, "R1", "idle after reset", {out_valid, ovf}, 0);
        tick();

        // R2: truncated coefficients through an impulse
        for (int i = 0; i < 128; i++) wcoef(i, 16'($urandom));
        wcoef(0, 16'hFFFF);
        wcoef(1, 16'h000F);
        wcoef(2, 16'h8000);
        wcoef(3, 16'h7FFF);
        cur_req = "R2";
        send(1000, 0, 1);
        for (int i = 0; i < 20; i++) send(0, 0, 1);
        drain();

        // R3: full-rate 16 taps
        cur_req = "R3";
        stream(40, 1);

        // R4: longer filters
        cur_req = "R4";
        len_mode = 2'd1; stream(40, 2);
        len_mode = 2'd2; stream(40, 4);
        len_mode = 2'd3; stream(140, 8);

        // R6: cascade added at full width
        cur_req = "R6";
        casc_a = 32'(-123456789);
        len_mode = 2'd1; stream(24, 2);
        casc_a = 32'd987654321;
        len_mode = 2'd0; stream(20, 1);

        // R7: split into two filters
        cur_req = "R7";
        casc_b = 32'd5555;
        split_en = 1'b1;
        len_mode = 2'd2; stream(30, 4);
        len_mode = 2'd3; stream(20, 8);
        len_mode = 2'd0; stream(20, 1);
        split_en = 1'b0;
        begin
            logic [31:0] held_b;
            held_b = res_b;
            stream(10, 1);
            @(negedge clk);
            chk(res_b == held_b, "R7", "res_b held when joined", res_b, held_b);
            tick();
        end

        // R8: decimate by two
        cur_req = "R8";
        decim_en = 1'b1;
        len_mode = 2'd3; stream(40, 4);
        len_mode = 2'd1; stream(20, 1);
        len_mode = 2'd0; stream(20, 1);
        split_en = 1'b1;
        len_mode = 2'd2; stream(20, 2);
        split_en = 1'b0;
        decim_en = 1'b0;

        // R5: wrap and sticky overflow
        cur_req = "R5";
        @(negedge clk);
        chk(ovf == 1'b0, "R5", "ovf clear before overflow", ovf, 0);
        chk(ovf_m == 1'b0, "R5", "model ovf clear", ovf_m, 0);
        tick();
        casc_a = '0;
        casc_b = '0;
        for (int i = 0; i < 128; i++) wcoef(i, 16'h7FF0);
        len_mode = 2'd3;
        for (int i = 0; i < 40; i++) send(32767, 0, 8);
        drain();
        @(negedge clk);
        chk(ovf == 1'b1, "R5", "ovf set after wrap", ovf, 1);
        tick();
        len_mode = 2'd0;
        for (int i = 0; i < 160; i++) send(0, 0, 1);
        drain();
        @(negedge clk);
        chk(ovf == 1'b1, "R5", "ovf remains set", ovf, 1);
        chk(due_q.size() == 0, "R9", "all results seen", due_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule